// File: doc/BRIEF.md
# Not-Most-Recently-Used Victim Pointer

This block picks the replacement victim for a fully associative store of 64 entries. It holds one rotating pointer that names the entry to evict next. The lookup logic reports each touched entry with an access strobe and an entry index. The pointer steps to the next entry only when the touched entry is the one it already names. As a result, the entry that was just used is never the next victim, and no history is kept for each entry.

A fill into the victim entry is reported like any other access, with the victim index, so the pointer steps past the newly filled entry. The current victim is shown in two forms. The first is a binary index, which the fill path uses as the write address. The second is a one-hot select vector, which drives the write enables of the entries directly. Tag matching is done elsewhere.

Top module: `evict_pointer_unit`

## Requirements
- R1: `victim_idx` is a 6-bit binary index, and it always names exactly one of the 64 entries (0 to 63).
- R2: While `rst_n` is low, the pointer is entry 0: `victim_idx` reads 0 and `victim_sel` reads 64'h1.
- R3: A cycle with `acc_valid` high and `acc_idx` equal to `victim_idx` makes the pointer step to the next entry. The new value shows after that clock edge.
- R4: A cycle with `acc_valid` high and `acc_idx` different from `victim_idx` leaves the pointer unchanged.
- R5: A cycle with `acc_valid` low leaves the pointer unchanged, whatever value `acc_idx` carries.
- R6: A step from entry 63 goes to entry 0.
- R7: `victim_sel` is one-hot, and its set bit is at position `victim_idx`.
- R8: A fill reported as an access to the victim index steps the pointer past the filled entry. Fills on back-to-back cycles step the pointer once per cycle, so 64 fills in a row return it to where it started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access strobe from the lookup or fill path |
| acc_idx | input | 6 | Index of the entry touched this cycle |
| victim_idx | output | 6 | Entry chosen for the next eviction |
| victim_sel | output | 64 | One-hot form of `victim_idx` |

## Verification
The only state is the pointer register, so every effect of an access appears exactly one rising edge later. `victim_sel` follows `victim_idx` in the same cycle, through logic only. The bench sets each strobe and index on a falling edge and updates its own reference pointer at the next rising edge. It then compares both outputs at the following falling edge, so each comparison looks at the one edge that could have changed the result. Reset is checked while it is held low, and again after it is released in the middle of a run.

// File: rtl/evict_ptr_pkg.sv
package evict_ptr_pkg;

  localparam int unsigned DEFAULT_ENTRIES = 64;

  // Index width needed to name n entries.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Successor of an entry, with a wrap after the last entry.
  function automatic int unsigned wrap_inc(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/evict_ptr_match.sv
module evict_ptr_match #(
  parameter int unsigned W = 6
) (
  input  logic         acc_valid,
  input  logic [W-1:0] acc_idx,
  input  logic [W-1:0] ptr,
  output logic         hit_victim
);
  // The pointed-to entry is touched this cycle.
  assign hit_victim = acc_valid && (acc_idx == ptr);
endmodule

// File: rtl/evict_ptr_reg.sv
module evict_ptr_reg #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned W       = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] ptr
);
  import evict_ptr_pkg::*;

  logic [W-1:0] ptr_next;

  always_comb begin
    ptr_next = ptr;
    if (step) ptr_next = W'(wrap_inc(int'(ptr), ENTRIES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_next;
  end
endmodule

// File: rtl/evict_ptr_decode.sv
module evict_ptr_decode #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned W       = 6
) (
  input  logic [W-1:0]       ptr,
  output logic [ENTRIES-1:0] sel
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
    assign sel[e] = (ptr == W'(e));
  end
endmodule

// File: rtl/evict_pointer_unit.sv
module evict_pointer_unit #(
  parameter int unsigned ENTRIES = evict_ptr_pkg::DEFAULT_ENTRIES,
  localparam int unsigned W      = evict_ptr_pkg::idx_width(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [W-1:0]       acc_idx,
  output logic [W-1:0]       victim_idx,
  output logic [ENTRIES-1:0] victim_sel
);
  // Named event: the current victim was touched, so the pointer steps.
  logic hit_victim;

  evict_ptr_match #(.W(W)) u_match (
    .acc_valid (acc_valid),
    .acc_idx   (acc_idx),
    .ptr       (victim_idx),
    .hit_victim(hit_victim)
  );

  evict_ptr_reg #(.ENTRIES(ENTRIES), .W(W)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .step (hit_victim),
    .ptr  (victim_idx)
  );

  evict_ptr_decode #(.ENTRIES(ENTRIES), .W(W)) u_dec (
    .ptr(victim_idx),
    .sel(victim_sel)
  );
endmodule

// File: rtl/evict_ptr_chk.sv
module evict_ptr_chk #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned W       = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [W-1:0]       acc_idx,
  input logic [W-1:0]       victim_idx,
  input logic [ENTRIES-1:0] victim_sel,
  input logic               hit_victim
);
  // R2: reset forces entry 0
  p_reset_zero_r2: assert property (@(posedge clk)
    !rst_n |=> victim_idx == '0);

  // R3, R8: touching the victim steps the pointer by one
  p_step_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_idx == victim_idx && victim_idx != W'(ENTRIES-1))
      |=> victim_idx == W'($past(victim_idx) + 1'b1));

  // R4: touching another entry holds the pointer
  p_hold_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_idx != victim_idx) |=> $stable(victim_idx));

  // R5: no strobe holds the pointer
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(victim_idx));

  // R6: the last entry wraps to zero
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_victim && victim_idx == W'(ENTRIES-1)) |=> victim_idx == '0);

  // R7: select vector is one-hot at the pointer
  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(victim_sel) == 1 && victim_sel[victim_idx]);

  // R1: the pointer never leaves the entry range
  p_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(victim_idx) < ENTRIES);
endmodule

bind evict_pointer_unit evict_ptr_chk #(.ENTRIES(ENTRIES), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_idx   (acc_idx),
  .victim_idx(victim_idx),
  .victim_sel(victim_sel),
  .hit_victim(hit_victim)
);

// File: tb/sim_evict_pointer_unit.sv
module sim_evict_pointer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [5:0]  acc_idx = '0;
  logic [5:0]  victim_idx;
  logic [63:0] victim_sel;

  int vectors = 0;
  int miscompares = 0;
  int model = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;  // 125 MHz

  evict_pointer_unit u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .victim_idx(victim_idx), .victim_sel(victim_sel)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic compare(input string req);
    logic [63:0] exp_sel;
    exp_sel = 64'h1 << model;
    vectors++;
    if (victim_idx !== 6'(model)) begin
      miscompares++;
      $display("FAIL %s victim_idx: actual %0d expected %0d", req, victim_idx, model);
    end
    if (victim_sel !== exp_sel) begin
      miscompares++;
      $display("FAIL R7 (%s) victim_sel: actual %h expected %h", req, victim_sel, exp_sel);
    end
  endtask

  // Drive on a falling edge, step the model at the rising edge, compare at the next falling edge.
  task automatic step(input logic v, input int idx, input string req);
    acc_valid = v;
    acc_idx   = 6'(idx);
    @(posedge clk);
    if (!rst_n) model = 0;
    else if (v && idx == model) model = (model + 1) % 64;
    @(negedge clk);
    compare(req);
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    // R2: reset state
    repeat (3) @(negedge clk);
    compare("R2");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R2");

    // R5: no strobe, index floating around including the victim
    step(1'b0, 0, "R5");
    step(1'b0, 17, "R5");

    // R4: other entries touched
    step(1'b1, 5, "R4");
    step(1'b1, 63, "R4");

    // R3: victim touched
    step(1'b1, 0, "R3");
    step(1'b1, 0, "R4");   // old victim re-touched: holds at 1
    step(1'b1, 1, "R3");

    // R8, R6: back-to-back fills walk the whole ring and wrap
    for (int i = 0; i < 64; i++) begin
      step(1'b1, model, (model == 63) ? "R6" : "R8");
    end
    if (model != 2) begin
      miscompares++;
      $display("FAIL R8 ring walk: actual %0d expected 2", model);
    end

    // R1, R3, R4, R5: mixed pattern
    for (int i = 0; i < 400; i++) begin
      int sel;
      lfsr = lfsr_next(lfsr);
      sel = int'(lfsr[2:0]);
      if (sel < 2)      step(1'b0, model, "R5");
      else if (sel < 5) step(1'b1, model, "R3");
      else              step(1'b1, (model + 1 + int'(lfsr[8:3]) % 63) % 64, "R4");
    end

    // R2: reset in mid-run
    rst_n = 1'b0;
    model = 0;
    #1;
    compare("R2");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 3, "R4");
    step(1'b1, 0, "R3");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule